// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register

This block holds the 16-bit basic control word of a 10/100 Ethernet PHY. A management port writes it through an address-decoded strobe and write data, and reads it back as a combinational word. The fields of the word drive the PHY core directly: soft reset, loopback, auto-negotiation enable and restart, power-down, isolate and collision test. The block also produces the effective speed and duplex that the datapath uses.

Two fields clear themselves: soft reset and negotiation restart. Each stays set until the PHY core returns its completion handshake. When the soft reset completes, the whole word returns to its reset value. Isolate and power-down cut the transmit inputs off from the core and raise the output-enable-low for the MII. Power-down also tristates the line driver and the LEDs. In collision-test mode, COL follows TX_EN, paced by a per-bit-time tick, so the same logic serves both line rates.

Top module: `phy_ctrl_reg`

## Requirements
- R1: After reset the word reads 0x1000 (only auto-negotiation enable, bit 12, is set). When the strapped PHY address is all zeros, the word reads 0x1400 instead: isolate (bit 10) is also set.
- R2: Bits 14 (loopback), 13 (speed, 1 = 100 Mb/s), 12 (negotiation enable), 11 (power-down), 10 (isolate), 8 (duplex, 1 = full) and 7 (collision test) are written and read back as written. Bits 6..0 always read 0, whatever is written to them.
- R3: Writing 1 to bit 15 asserts soft_reset. The bit is held, and a later write of 0 does not clear it. On the clock edge where reset_done arrives while it is set, the whole word returns to its strap-dependent reset value.
- R4: Writing 1 to bit 9 asserts an_restart. The bit is held, and a write of 0 does not clear it. It clears on the edge where an_restart_ack arrives.
- R5: While bit 12 is 1, eff_speed_100 and eff_full_duplex follow an_speed_100 and an_full_duplex. While bit 12 is 0, they follow bits 13 and 8.
- R6: While isolate is set, core_tx_en, core_tx_er and core_txd are forced to 0 and mii_oe_n is 1. The management port keeps reading and writing.
- R7: While power-down is set, mii_oe_n, line_tri and led_tri are all 1, and the transmit inputs are blocked as in R6.
- R8: With collision test set, col takes the value of the gated TX_EN at each bit_tick. It therefore rises one bit time after TX_EN rises and falls one bit time after TX_EN falls. With collision test clear, col passes core_col through.
- R9: reset_done without a pending soft reset, and an_restart_ack without a pending restart, leave the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_addr | input | ADDR_W | Strapped PHY address |
| mgmt_we | input | 1 | Decoded write strobe for this register |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Read data |
| reset_done | input | 1 | Soft reset complete |
| an_restart_ack | input | 1 | Negotiation restart taken |
| an_speed_100 | input | 1 | Negotiated speed, 1 = 100 Mb/s |
| an_full_duplex | input | 1 | Negotiated duplex, 1 = full |
| bit_tick | input | 1 | One pulse per bit time |
| tx_en | input | 1 | MII transmit enable |
| tx_er | input | 1 | MII transmit error |
| txd | input | TXD_W | MII transmit data |
| core_col | input | 1 | Collision from the PHY core |
| soft_reset | output | 1 | Soft reset request |
| loopback | output | 1 | Loopback mode |
| an_enable | output | 1 | Negotiation enabled |
| an_restart | output | 1 | Negotiation restart request |
| power_down | output | 1 | Power-down mode |
| isolate | output | 1 | Isolate mode |
| coltest_en | output | 1 | Collision test mode |
| eff_speed_100 | output | 1 | Effective speed |
| eff_full_duplex | output | 1 | Effective duplex |
| core_tx_en | output | 1 | Gated transmit enable to core |
| core_tx_er | output | 1 | Gated transmit error to core |
| core_txd | output | TXD_W | Gated transmit data to core |
| col | output | 1 | MII collision |
| mii_oe_n | output | 1 | Output enable low for MII outputs |
| line_tri | output | 1 | Line driver tristate |
| led_tri | output | 1 | LED tristate |

## Verification
The bench writes 0 to both self-clearing bits while they are pending. A design that treats them as plain read/write bits drops the reset or restart early. It also sends the completion handshakes when nothing is pending, to catch a design that clears or resets on a stray pulse. It resets once with a zero strap, so a fixed isolate reset value is exposed, and checks that a finished soft reset restores the whole word rather than just bit 15. In collision test it samples col before and after the bit tick, which catches a design that passes TX_EN straight through or never releases COL.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;

    localparam int REG_W = 16;
    localparam int RSV_W = 7;

    // Field order matches bit positions 15 down to 7
    typedef struct packed {
        logic rst;
        logic loopback;
        logic speed;
        logic an_en;
        logic pdown;
        logic iso;
        logic an_restart;
        logic duplex;
        logic coltest;
    } ctrl_t;

    function automatic ctrl_t ctrl_default(input logic iso_strap);
        ctrl_t c;
        c        = '0;
        c.an_en  = 1'b1;
        c.iso    = iso_strap;
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c);
        return {c, {RSV_W{1'b0}}};
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [REG_W-1:0] w);
        return ctrl_t'(w[REG_W-1:RSV_W]);
    endfunction

endpackage

// File: rtl/phy_ctrl_regfile.sv
module phy_ctrl_regfile
    import phy_ctrl_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              we,
    input  logic [REG_W-1:0]  wdata,
    input  logic              reset_done,
    input  logic              restart_ack,
    output ctrl_t             ctrl,
    output logic [REG_W-1:0]  rdata
);

    logic  iso_strap;
    ctrl_t wr;
    ctrl_t ctrl_nxt;

    assign iso_strap = (strap_addr == '0);
    assign wr        = ctrl_unpack(wdata);

    always_comb begin
        ctrl_nxt = ctrl;
        if (ctrl.an_restart && restart_ack)
            ctrl_nxt.an_restart = 1'b0;
        if (we) begin
            ctrl_nxt            = wr;
            ctrl_nxt.rst        = ctrl.rst | wr.rst;
            ctrl_nxt.an_restart = (ctrl.an_restart & ~restart_ack) | wr.an_restart;
        end
        if (ctrl.rst && reset_done)
            ctrl_nxt = ctrl_default(iso_strap);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= ctrl_default(iso_strap);
        else
            ctrl <= ctrl_nxt;
    end

    assign rdata = ctrl_pack(ctrl);

    AST_RST_HOLD: assert property (@(posedge clk) disable iff (rst)
        ctrl.rst && !reset_done |=> ctrl.rst); // R3
    AST_RST_DONE: assert property (@(posedge clk) disable iff (rst)
        ctrl.rst && reset_done |=> !ctrl.rst && ctrl.an_en && !ctrl.an_restart); // R3
    AST_RESTART_HOLD: assert property (@(posedge clk) disable iff (rst)
        ctrl.an_restart && !restart_ack && !(ctrl.rst && reset_done) |=> ctrl.an_restart); // R4
    AST_STRAY_DONE: assert property (@(posedge clk) disable iff (rst)
        !ctrl.rst && !we && !restart_ack |=> $stable(rdata)); // R9

endmodule

// File: rtl/phy_ctrl_resolve.sv
module phy_ctrl_resolve
    import phy_ctrl_pkg::*;
#(
    parameter int TXD_W = 4
) (
    input  ctrl_t             ctrl,
    input  logic              an_speed_100,
    input  logic              an_full_duplex,
    input  logic              tx_en,
    input  logic              tx_er,
    input  logic [TXD_W-1:0]  txd,
    output logic              eff_speed_100,
    output logic              eff_full_duplex,
    output logic              core_tx_en,
    output logic              core_tx_er,
    output logic [TXD_W-1:0]  core_txd,
    output logic              mii_oe_n,
    output logic              line_tri,
    output logic              led_tri
);

    logic cut_off;

    assign eff_speed_100   = ctrl.an_en ? an_speed_100   : ctrl.speed;
    assign eff_full_duplex = ctrl.an_en ? an_full_duplex : ctrl.duplex;

    assign cut_off    = ctrl.iso | ctrl.pdown;
    assign core_tx_en = tx_en & ~cut_off;
    assign core_tx_er = tx_er & ~cut_off;
    assign core_txd   = cut_off ? '0 : txd;
    assign mii_oe_n   = cut_off;
    assign line_tri   = ctrl.pdown;
    assign led_tri    = ctrl.pdown;

endmodule

// File: rtl/phy_ctrl_coltest.sv
module phy_ctrl_coltest (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic bit_tick,
    input  logic tx_en,
    input  logic core_col,
    output logic col
);

    logic col_q;

    always_ff @(posedge clk) begin
        if (rst || !enable)
            col_q <= 1'b0;
        else if (bit_tick)
            col_q <= tx_en;
    end

    assign col = enable ? col_q : core_col;

    AST_COL_RISE: assert property (@(posedge clk) disable iff (rst)
        enable && bit_tick && tx_en |=> (!enable || col)); // R8
    AST_COL_FALL: assert property (@(posedge clk) disable iff (rst)
        enable && bit_tick && !tx_en |=> (!enable || !col)); // R8

endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
    import phy_ctrl_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int TXD_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              mgmt_we,
    input  logic [15:0]       mgmt_wdata,
    output logic [15:0]       mgmt_rdata,
    input  logic              reset_done,
    input  logic              an_restart_ack,
    input  logic              an_speed_100,
    input  logic              an_full_duplex,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              tx_er,
    input  logic [TXD_W-1:0]  txd,
    input  logic              core_col,
    output logic              soft_reset,
    output logic              loopback,
    output logic              an_enable,
    output logic              an_restart,
    output logic              power_down,
    output logic              isolate,
    output logic              coltest_en,
    output logic              eff_speed_100,
    output logic              eff_full_duplex,
    output logic              core_tx_en,
    output logic              core_tx_er,
    output logic [TXD_W-1:0]  core_txd,
    output logic              col,
    output logic              mii_oe_n,
    output logic              line_tri,
    output logic              led_tri
);

    ctrl_t ctrl;

    phy_ctrl_regfile #(.ADDR_W(ADDR_W)) u_regfile (
        .clk         (clk),
        .rst         (rst),
        .strap_addr  (strap_addr),
        .we          (mgmt_we),
        .wdata       (mgmt_wdata),
        .reset_done  (reset_done),
        .restart_ack (an_restart_ack),
        .ctrl        (ctrl),
        .rdata       (mgmt_rdata)
    );

    phy_ctrl_resolve #(.TXD_W(TXD_W)) u_resolve (
        .ctrl            (ctrl),
        .an_speed_100    (an_speed_100),
        .an_full_duplex  (an_full_duplex),
        .tx_en           (tx_en),
        .tx_er           (tx_er),
        .txd             (txd),
        .eff_speed_100   (eff_speed_100),
        .eff_full_duplex (eff_full_duplex),
        .core_tx_en      (core_tx_en),
        .core_tx_er      (core_tx_er),
        .core_txd        (core_txd),
        .mii_oe_n        (mii_oe_n),
        .line_tri        (line_tri),
        .led_tri         (led_tri)
    );

    phy_ctrl_coltest u_coltest (
        .clk      (clk),
        .rst      (rst),
        .enable   (ctrl.coltest),
        .bit_tick (bit_tick),
        .tx_en    (core_tx_en),
        .core_col (core_col),
        .col      (col)
    );

    assign soft_reset = ctrl.rst;
    assign loopback   = ctrl.loopback;
    assign an_enable  = ctrl.an_en;
    assign an_restart = ctrl.an_restart;
    assign power_down = ctrl.pdown;
    assign isolate    = ctrl.iso;
    assign coltest_en = ctrl.coltest;

    AST_PD_CUTOFF: assert property (@(posedge clk) disable iff (rst)
        power_down |-> mii_oe_n && line_tri && led_tri && !core_tx_en); // R7
    AST_ISO_CUTOFF: assert property (@(posedge clk) disable iff (rst)
        isolate |-> mii_oe_n && !core_tx_en && !core_tx_er); // R6
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        mgmt_rdata[6:0] == 7'd0); // R2

endmodule

// File: tb/phy_ctrl_reg_tb.sv
module phy_ctrl_reg_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  strap_addr = 5'd3;
    logic        mgmt_we = 1'b0;
    logic [15:0] mgmt_wdata = '0;
    logic [15:0] mgmt_rdata;
    logic        reset_done = 1'b0, an_restart_ack = 1'b0;
    logic        an_speed_100 = 1'b0, an_full_duplex = 1'b0;
    logic        bit_tick = 1'b0, tx_en = 1'b0, tx_er = 1'b0;
    logic [3:0]  txd = '0;
    logic        core_col = 1'b0;
    logic        soft_reset, loopback, an_enable, an_restart, power_down, isolate, coltest_en;
    logic        eff_speed_100, eff_full_duplex, core_tx_en, core_tx_er, col;
    logic [3:0]  core_txd;
    logic        mii_oe_n, line_tri, led_tri;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    phy_ctrl_reg u_dut (
        .clk(clk), .rst(rst), .strap_addr(strap_addr),
        .mgmt_we(mgmt_we), .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata),
        .reset_done(reset_done), .an_restart_ack(an_restart_ack),
        .an_speed_100(an_speed_100), .an_full_duplex(an_full_duplex),
        .bit_tick(bit_tick), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
        .core_col(core_col), .soft_reset(soft_reset), .loopback(loopback),
        .an_enable(an_enable), .an_restart(an_restart), .power_down(power_down),
        .isolate(isolate), .coltest_en(coltest_en), .eff_speed_100(eff_speed_100),
        .eff_full_duplex(eff_full_duplex), .core_tx_en(core_tx_en),
        .core_tx_er(core_tx_er), .core_txd(core_txd), .col(col),
        .mii_oe_n(mii_oe_n), .line_tri(line_tri), .led_tri(led_tri)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic wr(input logic [15:0] v);
        @(negedge clk) begin mgmt_we = 1'b1; mgmt_wdata = v; end
        @(negedge clk) mgmt_we = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk) reset_done = 1'b1;
        @(negedge clk) reset_done = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk) an_restart_ack = 1'b1;
        @(negedge clk) an_restart_ack = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
    endtask

    task automatic t_reset_values();
        check("R1 word after reset", mgmt_rdata, 32'h1000);
        check("R1 an_enable", an_enable, 1);
        check("R1 mii_oe_n clear", mii_oe_n, 0);
        strap_addr = 5'd0;
        do_reset();
        check("R1 zero strap word", mgmt_rdata, 32'h1400);
        check("R6 zero strap isolate oe", mii_oe_n, 1);
        strap_addr = 5'd3;
        do_reset();
        check("R1 word after restrap", mgmt_rdata, 32'h1000);
    endtask

    task automatic t_rw();
        wr(16'h7DFF);
        check("R2 rw bits, reserved zero", mgmt_rdata, 32'h7D80);
        check("R2 loopback out", loopback, 1);
        wr(16'h0000);
        check("R2 all clear", mgmt_rdata, 32'h0000);
        wr(16'h2100);
        check("R2 speed+duplex", mgmt_rdata, 32'h2100);
    endtask

    task automatic t_resolve();
        an_speed_100 = 1'b0; an_full_duplex = 1'b0;
        wr(16'h2100);
        #1 check("R5 forced speed", eff_speed_100, 1);
        check("R5 forced duplex", eff_full_duplex, 1);
        wr(16'h0000);
        check("R5 forced 10 half", {eff_speed_100, eff_full_duplex}, 0);
        wr(16'h3000);
        an_speed_100 = 1'b1; an_full_duplex = 1'b0;
        #1 check("R5 negotiated 100 half", {eff_speed_100, eff_full_duplex}, 2);
        an_speed_100 = 1'b0; an_full_duplex = 1'b1;
        #1 check("R5 negotiated 10 full", {eff_speed_100, eff_full_duplex}, 1);
    endtask

    task automatic t_isolate();
        tx_en = 1'b1; tx_er = 1'b1; txd = 4'hA;
        wr(16'h0400);
        check("R6 tx gated", {core_tx_en, core_tx_er, core_txd}, 0);
        check("R6 oe_n", mii_oe_n, 1);
        check("R6 mgmt readback", mgmt_rdata, 32'h0400);
        wr(16'h0000);
        check("R6 tx passes", {core_tx_en, core_tx_er, core_txd}, 32'h3A);
        check("R6 oe_n released", mii_oe_n, 0);
    endtask

    task automatic t_powerdown();
        wr(16'h0800);
        check("R7 tristates", {mii_oe_n, line_tri, led_tri}, 7);
        check("R7 tx gated", core_tx_en, 0);
        wr(16'h0000);
        check("R7 released", {mii_oe_n, line_tri, led_tri}, 0);
        tx_en = 1'b0; tx_er = 1'b0; txd = '0;
    endtask

    task automatic t_restart();
        wr(16'h1200);
        check("R4 restart set", {an_restart, mgmt_rdata}, 32'h11200);
        wr(16'h1000);
        check("R4 write 0 keeps", mgmt_rdata, 32'h1200);
        pulse_ack();
        check("R4 ack clears", {an_restart, mgmt_rdata}, 32'h01000);
    endtask

    task automatic t_stray();
        wr(16'h2180);
        pulse_ack();
        check("R9 stray ack", mgmt_rdata, 32'h2180);
        pulse_done();
        check("R9 stray done", mgmt_rdata, 32'h2180);
    endtask

    task automatic t_softreset();
        wr(16'hA180);
        check("R3 reset set", {soft_reset, mgmt_rdata}, 32'h1A180);
        wr(16'h0000);
        check("R3 write 0 keeps", mgmt_rdata, 32'h8000);
        repeat (3) @(negedge clk);
        check("R3 held", soft_reset, 1);
        pulse_done();
        check("R3 done restores", {soft_reset, mgmt_rdata}, 32'h01000);
    endtask

    task automatic t_coltest();
        core_col = 1'b0;
        wr(16'h1080);
        @(negedge clk) tx_en = 1'b1;
        @(negedge clk);
        check("R8 col waits for tick", col, 0);
        pulse_tick();
        check("R8 col rises", col, 1);
        tx_en = 1'b0;
        @(negedge clk);
        check("R8 col holds till tick", col, 1);
        pulse_tick();
        check("R8 col falls", col, 0);
        wr(16'h1000);
        core_col = 1'b1;
        #1 check("R8 passthrough", col, 1);
        core_col = 1'b0;
    endtask

    initial begin
        do_reset();
        t_reset_values();
        t_rw();
        t_resolve();
        t_isolate();
        t_powerdown();
        t_restart();
        t_stray();
        t_softreset();
        t_coltest();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule